// File: doc/BRIEF.md
# Standard-Definition Luma/Chroma Level Control

This block sets the output levels of a standard-definition component video stream. Each Y, U and V sample is multiplied by its own 10-bit gain, where the code 512 stands for a gain of one. A signed brightness offset is then added to the scaled luma. Each product is clipped to the legal range of its channel. Samples arrive one per clock and are qualified by a valid strobe. The results leave through a short fixed-latency pipeline.

Gains and brightness are written through a byte-wide register port. Each gain keeps its upper eight bits in a register of its own. The two low bits of all three gains share one packed register. When buffered updates are enabled, writes collect in shadow registers. They reach the working settings only when VSYNC falls, so a change never lands in the middle of a field. With buffering off, a write applies from the next clock.

Top module: `sd_level_ctrl`

## Requirements
- R1: After reset, all three gains are 512 (unity) and brightness is 0. out_valid is low and out_y, out_u and out_v are zero.
- R2: Register map by reg_addr: 1, 2 and 3 hold bits [9:2] of the Y, U and V gains. Address 0 holds the low two gain bits: Y in bits [1:0], U in [3:2], V in [5:4]. Bits [7:6] of address 0 are ignored. Address 4 holds brightness as a 7-bit two's-complement value in bits [6:0], and its bit 7 is ignored. Writes to addresses 5 to 7 have no effect.
- R3: in_y is unsigned. out_y before brightness is min(1023, floor(in_y × gY / 512)). gY is the Y gain limited to at most 768 (a gain of 1.5).
- R4: in_u and in_v are two's complement. Each output is floor(x × g / 512), clipped to the range −512..511.
- R5: The brightness offset is floor(b × 7 / 2) codes, where b is the signed brightness field. It is added to the scaled Y, and the sum is clipped to 0..1023. U and V are not affected.
- R6: When in_valid is sampled high at clock edge k, out_valid is high after edge k+1 and the results are shown on the outputs. When out_valid is low, all three data outputs are zero.
- R7: With db_en low, a write taken at edge k is used by a sample captured at edge k+1.
- R8: With db_en high, writes are held back. The working settings load the shadow values only at an edge where vsync is sampled low after being sampled high on the edge before. A rising vsync or a steady vsync changes nothing.
- R9: When db_en is sampled low, any pending shadow values load at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| db_en | input | 1 | Enables field-synchronous buffered updates |
| vsync | input | 1 | Vertical sync, sampled on clk |
| in_valid | input | 1 | Input sample qualifier |
| in_y | input | 10 | Luma sample, unsigned |
| in_u | input | 10 | U sample, two's complement |
| in_v | input | 10 | V sample, two's complement |
| out_valid | output | 1 | Output sample qualifier |
| out_y | output | 10 | Scaled and offset luma |
| out_u | output | 10 | Scaled U |
| out_v | output | 10 | Scaled V |

## Verification
A sample captured at edge k is due after edge k+1. The bench drives it at a falling edge and checks that out_valid is still low after edge k. It reads the results at the falling edge after edge k+1. A register write or a vsync level drives the reference model at the rising edge that samples it, so the model's working settings change in the same cycle as the design's. A sample that follows a write therefore checks the one-clock update of R7. The same holds for the edge-exact transfer of R8 and R9.

// File: rtl/lvl_pkg.sv
// Shared types and register constants for the level-control block.
// Assumes a 10-bit gain split as an 8-bit upper byte plus a 2-bit field.
package lvl_pkg;
    localparam int SCALE_W = 10;
    localparam int HI_W    = 8;
    localparam int LO_W    = SCALE_W - HI_W;
    localparam int BRT_W   = 7;
    localparam int NCH     = 3;
    localparam int REG_AW  = 3;
    localparam int REG_DW  = 8;

    typedef enum logic [REG_AW-1:0] {
        RA_LSB = 3'd0,
        RA_YHI = 3'd1,
        RA_UHI = 3'd2,
        RA_VHI = 3'd3,
        RA_BRT = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [NCH-1:0][SCALE_W-1:0] sc;
        logic [BRT_W-1:0]            brt;
    } lvl_set_t;

    localparam logic [SCALE_W-1:0] SCALE_UNITY = SCALE_W'(512);
    localparam lvl_set_t LVL_RESET = '{sc: {NCH{SCALE_UNITY}}, brt: '0};
endpackage

// File: rtl/lvl_regfile.sv
// Register file: shadow copies of the gains and brightness, plus the
// working copy that feeds the datapath. The working copy loads on every
// clock when buffering is off. Otherwise it loads once per vsync fall.
// Assumes vsync is already synchronous to clk.
module lvl_regfile
    import lvl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic              db_en,
    input  logic              vsync,
    output lvl_set_t          act
);
    logic [NCH-1:0][HI_W-1:0] hi_q, hi_n;
    logic [NCH-1:0][LO_W-1:0] lo_q, lo_n;
    logic [BRT_W-1:0]         brt_q, brt_n;
    logic                     vs_q;
    logic                     vs_fall;
    logic                     load;
    lvl_set_t                 nxt;

    // Next shadow contents after this cycle's write.
    always_comb begin
        hi_n  = hi_q;
        lo_n  = lo_q;
        brt_n = brt_q;
        if (we) begin
            case (reg_addr_e'(addr))
                RA_LSB: begin
                    for (int c = 0; c < NCH; c++) begin
                        lo_n[c] = wdata[c*LO_W +: LO_W];
                    end
                end
                RA_YHI:  hi_n[0] = wdata;
                RA_UHI:  hi_n[1] = wdata;
                RA_VHI:  hi_n[2] = wdata;
                RA_BRT:  brt_n   = wdata[BRT_W-1:0];
                default: ;
            endcase
        end
    end

    // Reassemble each 10-bit gain from its byte and its packed field.
    for (genvar c = 0; c < NCH; c++) begin : g_join
        assign nxt.sc[c] = {hi_n[c], lo_n[c]};
    end
    assign nxt.brt = brt_n;

    // Shadow storage; reset gives unity gains and zero brightness.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= {NCH{SCALE_UNITY[SCALE_W-1:LO_W]}};
            lo_q  <= '0;
            brt_q <= '0;
        end else begin
            hi_q  <= hi_n;
            lo_q  <= lo_n;
            brt_q <= brt_n;
        end
    end

    // Previous vsync sample, used to detect the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= vsync;
    end

    assign vs_fall = vs_q & ~vsync;
    assign load    = ~db_en | vs_fall;

    // Working settings: copy the shadow when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)    act <= LVL_RESET;
        else if (load) act <= nxt;
    end
endmodule

// File: rtl/lvl_scale_ch.sv
// One channel gain stage: limits the gain, multiplies, drops FRAC bits
// (floor) and clips. SIGNED_IN selects the two's-complement variant.
// The result is registered when en is high.
module lvl_scale_ch #(
    parameter int W         = 10,
    parameter int SW        = 10,
    parameter int FRAC      = 9,
    parameter bit SIGNED_IN = 1'b0,
    parameter int SCALE_MAX = 1023
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [W-1:0]  sample,
    input  logic [SW-1:0] scale,
    output logic [W-1:0]  res
);
    localparam int PW = W + SW + 2;

    logic [SW-1:0] eff;
    logic [W-1:0]  clip;

    // Limit the gain to this channel's allowed maximum.
    assign eff = (scale > SW'(SCALE_MAX)) ? SW'(SCALE_MAX) : scale;

    if (SIGNED_IN) begin : g_signed
        localparam int HI_V = 2**(W-1) - 1;
        localparam int LO_V = -(2**(W-1));
        logic signed [PW-1:0] prod, shp;
        // Signed product, floor shift and symmetric clip.
        always_comb begin
            prod = PW'($signed({sample[W-1], sample})) * PW'($signed({1'b0, eff}));
            shp  = prod >>> FRAC;
            if (shp > PW'(HI_V))      clip = W'(HI_V);
            else if (shp < PW'(LO_V)) clip = W'(LO_V);
            else                      clip = shp[W-1:0];
        end
    end else begin : g_unsigned
        localparam int HI_V = 2**W - 1;
        logic [PW-1:0] prod, shp;
        // Unsigned product, floor shift and top clip.
        always_comb begin
            prod = PW'(sample) * PW'(eff);
            shp  = prod >> FRAC;
            if (shp > PW'(HI_V)) clip = W'(HI_V);
            else                 clip = shp[W-1:0];
        end
    end

    // Stage register for the scaled value.
    always_ff @(posedge clk) begin
        if (!rst_n)  res <= '0;
        else if (en) res <= clip;
    end
endmodule

// File: rtl/lvl_bright.sv
// Brightness adder: sign-extends the brightness field, converts it to
// codes as floor(b*MUL/2^SHIFT) and adds it to unsigned luma, with a
// clip to 0..2^W-1. Purely combinational.
module lvl_bright #(
    parameter int W     = 10,
    parameter int BW    = 7,
    parameter int MUL   = 7,
    parameter int SHIFT = 1
) (
    input  logic [W-1:0]  y_in,
    input  logic [BW-1:0] brt,
    output logic [W-1:0]  y_out
);
    localparam int SUMW = W + BW + 12;
    localparam int HI_V = 2**W - 1;

    logic signed [SUMW-1:0] b_ext, off, sum;

    // Offset in codes, added and clipped to the unsigned range.
    always_comb begin
        b_ext = SUMW'($signed(brt));
        off   = (b_ext * SUMW'(MUL)) >>> SHIFT;
        sum   = SUMW'($signed({1'b0, y_in})) + off;
        if (sum < 0)                 y_out = '0;
        else if (sum > SUMW'(HI_V))  y_out = W'(HI_V);
        else                         y_out = sum[W-1:0];
    end
endmodule

// File: rtl/sd_level_ctrl.sv
// Top of the level control: register file, three gain stages
// (stage 1) and a brightness/output stage (stage 2). A sample captured
// at edge k is shown after edge k+1. The outputs are zero when not valid.
module sd_level_ctrl #(
    parameter int SAMPLE_W     = 10,
    parameter int FRAC_BITS    = 9,
    parameter int Y_SCALE_MAX  = 768,
    parameter int UV_SCALE_MAX = 1023,
    parameter int BRT_MUL      = 7,
    parameter int BRT_SHIFT    = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic                db_en,
    input  logic                vsync,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_y,
    input  logic [SAMPLE_W-1:0] in_u,
    input  logic [SAMPLE_W-1:0] in_v,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_y,
    output logic [SAMPLE_W-1:0] out_u,
    output logic [SAMPLE_W-1:0] out_v
);
    import lvl_pkg::*;

    lvl_set_t                         act_set;
    logic [NCH-1:0][SAMPLE_W-1:0]     samp;
    logic [NCH-1:0][SAMPLE_W-1:0]     s1;
    logic                             v1;
    logic [SAMPLE_W-1:0]              y_bright;

    lvl_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .db_en (db_en),
        .vsync (vsync),
        .act   (act_set)
    );

    assign samp = {in_v, in_u, in_y};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lvl_scale_ch #(
            .W         (SAMPLE_W),
            .SW        (SCALE_W),
            .FRAC      (FRAC_BITS),
            .SIGNED_IN (c != 0),
            .SCALE_MAX (c == 0 ? Y_SCALE_MAX : UV_SCALE_MAX)
        ) u_scale (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (in_valid),
            .sample (samp[c]),
            .scale  (act_set.sc[c]),
            .res    (s1[c])
        );
    end

    // Stage-1 valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) v1 <= 1'b0;
        else        v1 <= in_valid;
    end

    lvl_bright #(
        .W     (SAMPLE_W),
        .BW    (BRT_W),
        .MUL   (BRT_MUL),
        .SHIFT (BRT_SHIFT)
    ) u_bright (
        .y_in  (s1[0]),
        .brt   (act_set.brt),
        .y_out (y_bright)
    );

    // Output stage: registered results, zeroed when not valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_y     <= '0;
            out_u     <= '0;
            out_v     <= '0;
        end else begin
            out_valid <= v1;
            out_y     <= v1 ? y_bright : '0;
            out_u     <= v1 ? s1[1]    : '0;
            out_v     <= v1 ? s1[2]    : '0;
        end
    end
endmodule

// File: rtl/lvl_ctrl_chk.sv
// Timing and hold properties for sd_level_ctrl, attached by bind.
module lvl_ctrl_chk #(
    parameter int W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               db_en,
    input logic               vsync,
    input logic               in_valid,
    input logic               out_valid,
    input logic [W-1:0]       out_y,
    input logic [W-1:0]       out_u,
    input logic [W-1:0]       out_v,
    input lvl_pkg::lvl_set_t  act
);
    // R6
    valid_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R6
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_y == '0 && out_u == '0 && out_v == '0));

    // R8
    buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_en && !$fell(vsync)) |=> $stable(act));
endmodule

bind sd_level_ctrl lvl_ctrl_chk #(.W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .db_en     (db_en),
    .vsync     (vsync),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_y     (out_y),
    .out_u     (out_u),
    .out_v     (out_v),
    .act       (act_set)
);

// File: tb/sim_sd_level_ctrl.sv
module sim_sd_level_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       db_en = 1'b0;
    logic       vsync = 1'b0;
    logic       in_valid = 1'b0;
    logic [9:0] in_y = '0, in_u = '0, in_v = '0;
    logic       out_valid;
    logic [9:0] out_y, out_u, out_v;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    int hi[3];
    int lo[3];
    int sh_brt;
    int act_sc[3];
    int act_brt;
    bit m_db = 0;
    bit m_vs = 0;

    always #10 clk = ~clk;

    sd_level_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .db_en(db_en), .vsync(vsync),
        .in_valid(in_valid), .in_y(in_y), .in_u(in_u), .in_v(in_v),
        .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void copy_shadow();
        for (int c = 0; c < 3; c++) act_sc[c] = hi[c] * 4 + lo[c];
        act_brt = sh_brt;
    endfunction

    function automatic int exp_y(int y);
        int g, p, b, off, r;
        g = (act_sc[0] > 768) ? 768 : act_sc[0];
        p = (y * g) >>> 9;
        if (p > 1023) p = 1023;
        b = (act_brt >= 64) ? act_brt - 128 : act_brt;
        off = (b * 7) >>> 1;
        r = p + off;
        if (r < 0) r = 0;
        if (r > 1023) r = 1023;
        return r;
    endfunction

    function automatic int exp_c(int x, int c);
        int p;
        p = (x * act_sc[c]) >>> 9;
        if (p > 511) p = 511;
        if (p < -512) p = -512;
        return p;
    endfunction

    task automatic wr(input int a, input int d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(posedge clk);
        case (a)
            0: for (int c = 0; c < 3; c++) lo[c] = (d >> (2*c)) & 3;
            1: hi[0] = d & 255;
            2: hi[1] = d & 255;
            3: hi[2] = d & 255;
            4: sh_brt = d & 127;
            default: ;
        endcase
        if (!m_db) copy_shadow();
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_db(input bit v);
        db_en = v;
        @(posedge clk);
        m_db = v;
        if (!v) copy_shadow();
        @(negedge clk);
    endtask

    task automatic set_vs(input bit v);
        vsync = v;
        @(posedge clk);
        if (m_db && m_vs && !v) copy_shadow();
        m_vs = v;
        @(negedge clk);
    endtask

    task automatic sample(input int y, input int u, input int v, input string req);
        in_valid = 1'b1; in_y = 10'(y); in_u = 10'(u); in_v = 10'(v);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check("R6", "out_valid before result", int'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check("R6", "out_valid", int'(out_valid), 1);
        check(req, "out_y", int'(out_y), exp_y(y));
        check(req, "out_u", int'($signed(out_u)), exp_c(u, 1));
        check(req, "out_v", int'($signed(out_v)), exp_c(v, 2));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 3; c++) begin hi[c] = 128; lo[c] = 0; end
        sh_brt = 0;
        copy_shadow();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "out_y in reset", int'(out_y), 0);
        check("R1", "out_u in reset", int'(out_u), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "out_v after reset", int'(out_v), 0);
        sample(300, -100, 50, "R1");

        // gain 665 on all three channels: A6h uppers, 15h packed lows
        wr(1, 'hA6); wr(2, 'hA6); wr(3, 'hA6); wr(0, 'h15);
        sample(200, 400, -300, "R2");
        sample(1000, -77, 123, "R3");
        // Y gain written 1023 is limited to 768
        wr(1, 'hFF); wr(0, 'h03);
        sample(400, 10, 10, "R3");
        wr(2, 'hFF); wr(3, 'hFF); wr(0, 'h3F);
        sample(0, -512, 511, "R4");
        sample(0, 300, -300, "R4");

        wr(1, 'h80); wr(2, 'h80); wr(3, 'h80); wr(0, 'h00);
        wr(4, 'h28);
        sample(100, 10, -10, "R5");
        wr(4, 'h72);
        sample(100, 10, -10, "R5");
        sample(20, 0, 0, "R5");
        wr(4, 'h3F);
        sample(1000, 5, 5, "R5");
        // bit 7 of brightness ignored
        wr(4, 'hA8);
        sample(100, 1, 1, "R2");
        // bits 7:6 of the packed register and addresses 5..7 ignored
        wr(0, 'hC0); wr(5, 'h00); wr(6, 'h11); wr(7, 'hFF);
        sample(333, -44, 55, "R2");
        // R7: write applies to a sample captured on the next edge
        wr(2, 'h40);
        sample(0, 200, 0, "R7");

        // R8: buffered updates wait for a vsync fall
        set_db(1'b1);
        wr(4, 'h00); wr(1, 'h40);
        sample(100, 200, 0, "R8");
        set_vs(1'b1);
        sample(100, 200, 0, "R8");
        set_vs(1'b0);
        sample(100, 200, 0, "R8");
        set_vs(1'b1); set_vs(1'b0);
        sample(100, 200, 0, "R8");
        // R9: pending values load when buffering is turned off
        wr(1, 'h80);
        sample(100, 0, 0, "R9");
        set_db(1'b0);
        sample(100, 0, 0, "R9");

        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 2)      wr($urandom_range(0, 7), $urandom_range(0, 255));
            else if (op == 3) set_db(1'($urandom_range(0, 1)));
            else if (op == 4) set_vs(~m_vs);
            else sample($urandom_range(0, 1023), int'($urandom_range(0, 1023)) - 512,
                        int'($urandom_range(0, 1023)) - 512, "R8");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule